// File: doc/BRIEF.md
# External Clock Source Select Controller

This block decides whether the system clock should come from an external source instead of the internal oscillators. Software writes a 4-bit select code and a lock bit through a simple single-cycle register write port. The lock bit can only be cleared. Once it is cleared, the select code is frozen until the next reset.

The select code only counts when two conditions hold together. The first is a qualifier showing that the life-cycle state permits test clocking, which means a test or return-for-analysis state. The second is a design-for-test enable. Both qualifiers are 4-bit encoded words. Only one exact encoding counts as "on", so a single flipped bit fails safe. When the code and both qualifiers agree, the block raises a bypass request toward the clock source. After the source acknowledges, the block reports that the external clock is in use. When the conditions drop, the request falls at once. The in-use status stays up until the source withdraws its acknowledge.

Top module: `extsel_ctrl`

## Requirements
- R1: After reset the lock bit reads 1, the select code reads 4'h5, and both the bypass request and the external-active status are 0.
- R2: A write to the lock register (wr_reg_i = 0) with wr_data_i[0] = 0 clears the lock bit on the next cycle. A write with wr_data_i[0] = 1 has no effect. Once the lock bit is 0 it stays 0 until reset.
- R3: While the lock bit is 0, writes to the select register (wr_reg_i = 1) leave the select code unchanged.
- R4: While the lock bit is 1, a write to the select register loads wr_data_i into the select code, visible on sel_o on the next cycle.
- R5: The bypass request is high in a cycle exactly when, in the previous cycle, the select code was 4'hA and both qualifier inputs equalled the on-encoding 4'b0110. Every other select value and every other qualifier encoding keeps the request low.
- R6: The external-active status rises in the cycle after the acknowledge is sampled high while the request is high.
- R7: Once set, the external-active status stays high while the acknowledge stays high, even after the request falls. It clears in the cycle after the acknowledge is sampled low.
- R8: An acknowledge that arrives while the request and status are both low does not set the external-active status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_reg_i | input | 1 | Register index: 0 lock, 1 select |
| wr_data_i | input | 4 | Write data |
| lc_test_i | input | 4 | Life-cycle test-permitted qualifier, on = 4'b0110 |
| dft_en_i | input | 4 | Design-for-test enable qualifier, on = 4'b0110 |
| byp_ack_i | input | 1 | Acknowledge from the clock source |
| byp_req_o | output | 1 | Bypass request to the clock source |
| ext_active_o | output | 1 | System clock runs from the external source |
| sel_o | output | 4 | Current select code |
| wen_o | output | 1 | Current lock bit (1 = select writable) |

## Verification
A corrupted lock or select register shows on wen_o or sel_o in the cycle after the write. It also moves byp_req_o one cycle later, because the request is registered from the stored code. A handshake state that is wrong shows on ext_active_o within one cycle of an acknowledge edge. The most telling cases are: a request withdrawn before the acknowledge arrives, an acknowledge that lingers after the request falls, and qualifier words that are one bit away from the on-encoding.

// File: rtl/extsel_pkg.sv
package extsel_pkg;
  typedef enum logic {
    REG_LOCK = 1'b0,
    REG_SEL  = 1'b1
  } extsel_reg_e;
endpackage

// File: rtl/extsel_regs.sv
module extsel_regs
  import extsel_pkg::*;
#(
  parameter int unsigned SelW = 4,
  parameter logic [SelW-1:0] SelRst = 4'h5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic            wr_reg_i,
  input  logic [SelW-1:0] wr_data_i,
  output logic            wen_o,
  output logic [SelW-1:0] sel_o
);
  logic            wen_q, wen_d;
  logic [SelW-1:0] sel_q, sel_d;
  logic            lock_wr, sel_wr;

  always_comb begin
    lock_wr = wr_en_i && (extsel_reg_e'(wr_reg_i) == REG_LOCK);
    sel_wr  = wr_en_i && (extsel_reg_e'(wr_reg_i) == REG_SEL) && wen_q;
    wen_d   = (lock_wr && !wr_data_i[0]) ? 1'b0 : wen_q;
    sel_d   = sel_wr ? wr_data_i : sel_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wen_q <= 1'b1;
      sel_q <= SelRst;
    end else begin
      wen_q <= wen_d;
      sel_q <= sel_d;
    end
  end

  assign wen_o = wen_q;
  assign sel_o = sel_q;

  // R2: a cleared lock never returns to 1 before reset
  p_lock_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wen_q |=> !wen_q);
  // R3: the select code is frozen while locked
  p_sel_frozen_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wen_q |=> $stable(sel_q));
endmodule

// File: rtl/extsel_qual.sv
module extsel_qual #(
  parameter int unsigned SelW    = 4,
  parameter logic [SelW-1:0] SelOn = 4'hA,
  parameter int unsigned MuW     = 4,
  parameter logic [MuW-1:0] MuOn = 4'b0110,
  parameter int unsigned NumQual = 2
) (
  input  logic [SelW-1:0]             sel_i,
  input  logic [NumQual-1:0][MuW-1:0] qual_i,
  output logic                        go_o
);
  logic [NumQual-1:0] on_vec;

  for (genvar g = 0; g < NumQual; g++) begin : g_qual
    assign on_vec[g] = (qual_i[g] == MuOn);
  end

  assign go_o = (sel_i == SelOn) && (&on_vec);
endmodule

// File: rtl/extsel_hshake.sv
module extsel_hshake (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic ack_i,
  output logic req_o,
  output logic act_o
);
  logic req_q, req_d;
  logic act_q, act_d;

  always_comb begin
    req_d = go_i;
    act_d = ack_i && (req_q || act_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      act_q <= 1'b0;
    end else begin
      req_q <= req_d;
      act_q <= act_d;
    end
  end

  assign req_o = req_q;
  assign act_o = act_q;

  // R6: status only rises after an acknowledge seen with the request high
  p_rise_needs_ack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_q) |-> $past(ack_i && req_q));
  // R7: status holds while the acknowledge stays up
  p_hold_on_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && ack_i) |=> act_q);
  // R7: a low acknowledge clears the status
  p_clear_on_nack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |=> !act_q);
endmodule

// File: rtl/extsel_ctrl.sv
module extsel_ctrl #(
  parameter int unsigned SelW = 4,
  parameter logic [SelW-1:0] SelRst = 4'h5,
  parameter logic [SelW-1:0] SelOn  = 4'hA,
  parameter int unsigned MuW = 4,
  parameter logic [MuW-1:0] MuOn = 4'b0110
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic            wr_reg_i,
  input  logic [SelW-1:0] wr_data_i,
  input  logic [MuW-1:0]  lc_test_i,
  input  logic [MuW-1:0]  dft_en_i,
  input  logic            byp_ack_i,
  output logic            byp_req_o,
  output logic            ext_active_o,
  output logic [SelW-1:0] sel_o,
  output logic            wen_o
);
  localparam int unsigned NumQual = 2;

  logic [SelW-1:0]             sel;
  logic [NumQual-1:0][MuW-1:0] quals;
  logic                        go;

  assign quals = {dft_en_i, lc_test_i};

  extsel_regs #(.SelW(SelW), .SelRst(SelRst)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_reg_i  (wr_reg_i),
    .wr_data_i (wr_data_i),
    .wen_o     (wen_o),
    .sel_o     (sel)
  );

  extsel_qual #(.SelW(SelW), .SelOn(SelOn), .MuW(MuW), .MuOn(MuOn),
                .NumQual(NumQual)) u_qual (
    .sel_i  (sel),
    .qual_i (quals),
    .go_o   (go)
  );

  extsel_hshake u_hs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (go),
    .ack_i  (byp_ack_i),
    .req_o  (byp_req_o),
    .act_o  (ext_active_o)
  );

  assign sel_o = sel;

  // R5: a request implies the previous cycle held the enabling select code
  p_req_needs_code_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byp_req_o |-> ($past(sel) == SelOn));
  // R5: a request implies both qualifiers were on in the previous cycle
  p_req_needs_qual_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byp_req_o |-> ($past(lc_test_i) == MuOn && $past(dft_en_i) == MuOn));
  // R8: an acknowledge while idle does not set the status
  p_no_stray_act_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!byp_req_o && !ext_active_o) |=> !ext_active_o);
endmodule

// File: tb/extsel_ctrl_test.sv
module extsel_ctrl_test;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [3:0] ON  = 4'b0110;
  localparam logic [3:0] OFF = 4'b1001;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_reg = 1'b0;
  logic [3:0] wr_data = '0;
  logic [3:0] lc = OFF;
  logic [3:0] dft = OFF;
  logic       ack = 1'b0;
  logic       req, act, wen;
  logic [3:0] sel;

  int n_tests = 0;
  int n_fail = 0;

  logic       m_wen, m_req, m_act;
  logic [3:0] m_sel;

  always #(CLK_PERIOD/2) clk = ~clk;

  extsel_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_reg_i(wr_reg),
    .wr_data_i(wr_data), .lc_test_i(lc), .dft_en_i(dft), .byp_ack_i(ack),
    .byp_req_o(req), .ext_active_o(act), .sel_o(sel), .wen_o(wen)
  );

  function automatic logic exp_go(logic [3:0] s, logic [3:0] l, logic [3:0] d);
    return (s == 4'hA) && (l == ON) && (d == ON);
  endfunction

  task automatic chk(string tag, logic [3:0] got, logic [3:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step();
    logic nreq, nact, nwen;
    logic [3:0] nsel;
    nreq = exp_go(m_sel, lc, dft);
    nact = ack && (m_req || m_act);
    nwen = (wr_en && wr_reg == 1'b0 && !wr_data[0]) ? 1'b0 : m_wen;
    nsel = (wr_en && wr_reg == 1'b1 && m_wen) ? wr_data : m_sel;
    @(posedge clk);
    m_req = nreq; m_act = nact; m_wen = nwen; m_sel = nsel;
    #1;
    chk("R2 lock bit", {3'b0, wen}, {3'b0, m_wen});
    chk("R3/R4 select code", sel, m_sel);
    chk("R5 bypass request", {3'b0, req}, {3'b0, m_req});
    chk("R6/R7/R8 active status", {3'b0, act}, {3'b0, m_act});
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr(logic r, logic [3:0] d);
    wr_en = 1'b1; wr_reg = r; wr_data = d;
    step();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_wen = 1'b1; m_sel = 4'h5; m_req = 1'b0; m_act = 1'b0;
    #(CLK_PERIOD * 2 + 1);
    // R1 reset values
    chk("R1 lock reset", {3'b0, wen}, 4'h1);
    chk("R1 select reset", sel, 4'h5);
    chk("R1 request reset", {3'b0, req}, 4'h0);
    chk("R1 active reset", {3'b0, act}, 4'h0);
    @(negedge clk); rst_n = 1'b1;
    step();
    // R8: acknowledge while idle
    ack = 1'b1; step(); step(); ack = 1'b0; step();
    // R4: load the enabling code, qualifiers on, then handshake (R5, R6)
    lc = ON; dft = ON;
    wr(1'b1, 4'hA);
    step();
    chk("R5 request up", {3'b0, req}, 4'h1);
    ack = 1'b1; step();
    chk("R6 active up", {3'b0, act}, 4'h1);
    // R7: drop the qualifier with one bit off, status holds while ack
    dft = 4'b0111; step(); step();
    chk("R7 active held after request fell", {3'b0, act}, 4'h1);
    ack = 1'b0; step();
    chk("R7 active cleared", {3'b0, act}, 4'h0);
    // R5: lc one bit off; request withdrawn before acknowledge
    dft = ON; lc = 4'b0100; step(); step();
    lc = ON; step(); lc = OFF; step(); ack = 1'b1; step(); step(); ack = 1'b0; step();
    // R2: writing 1 to lock has no effect, writing 0 clears
    wr(1'b0, 4'h1); wr(1'b1, 4'h3);
    wr(1'b0, 4'hE);
    chk("R2 lock cleared", {3'b0, wen}, 4'h0);
    // R3: select writes ignored, lock sticky
    wr(1'b1, 4'hA); wr(1'b0, 4'hF); wr(1'b1, 4'h0);
    chk("R3 select frozen", sel, 4'h3);
    // reset again for random phase
    @(negedge clk); rst_n = 1'b0;
    m_wen = 1'b1; m_sel = 4'h5; m_req = 1'b0; m_act = 1'b0;
    #(CLK_PERIOD); @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      wr_en   = ($urandom % 8) == 0;
      wr_reg  = ($urandom % 64) != 0;
      wr_data = (($urandom % 2) == 0) ? 4'hA : 4'($urandom);
      lc      = (($urandom % 8) != 0) ? ON : 4'($urandom);
      dft     = (($urandom % 8) != 0) ? ON : 4'($urandom);
      ack     = (($urandom % 4) == 0) ? ~m_req : m_req;
      step();
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule